// File: doc/BRIEF.md
# Paged 48-Line GPIO Controller with Edge-Capture Interrupts

This block is a register-mapped general-purpose I/O controller on a small 8-bit host bus with a 4-bit address, separate write and read strobes, and separate write and read data. It serves 48 lines grouped into six 8-bit ports. A port write loads that port's output latch. A latch bit of 1 drives its line, and a latch bit of 0 releases the line so that it can be used as an input. A port read returns the line levels after a two-flop synchronizer. No separate direction register exists.

The first 24 lines (ports 0, 1 and 2) can capture a rising or a falling edge. A captured edge raises one level-sensitive interrupt output. A page register at offset 7 chooses which bank of per-port interrupt registers appears at offsets 8, 9 and 10. The three banks are the enable bank, the edge-polarity bank and the captured-event bank. Offset 6 gives a summary of pending ports. Software acknowledges an event by writing its enable bit to 0 and then writing it back to 1.

Read data is registered. It appears on the cycle after the one in which the read strobe is sampled. Writes take effect at the clock edge that samples the write strobe.

Top module: `gpio48_edge_ctrl`

## Requirements
- R1: After reset, all output latches, enables, polarities and captured events are 0, the interrupt output is low, and offset 7 reads 0xC0 (event page selected).
- R2: A write to offset p (0 to 5) loads that port's latch. Output-enable pin bit 8p+b equals latch bit b from the next cycle. A latch bit of 1 drives the line and a bit of 0 releases it.
- R3: A read of offset p (0 to 5) returns the synchronized levels of lines 8p to 8p+7, with bit b equal to line 8p+b.
- R4: A write to offset 7 with 0x80 selects the enable page, 0x40 selects the polarity page and 0xC0 selects the event page. Any other value leaves the page unchanged. A read of offset 7 returns the current page code.
- R5: In the enable page, offsets 8, 9 and 10 read and write the enable bytes of ports 0, 1 and 2.
- R6: In the polarity page, offsets 8 to 10 read and write the polarity bytes. A polarity bit of 1 captures a rising edge on that line, and a 0 captures a falling edge.
- R7: An event is captured only on a line whose enable bit is 1 when the selected edge is seen. Edges on ports 3 to 5 never capture an event.
- R8: In the event page, a read of offset 8+p returns the bitmap of captured events of port p. Writes to offsets 8 to 10 in this page change nothing.
- R9: Writing a line's enable bit to 0 clears its captured event. After the bit is set back to 1, a later selected edge on that line is captured again.
- R10: Offset 6 reads back bit p (p = 0 to 2) as the OR of port p's captured events. Bits 7:3 read as 0.
- R11: The interrupt output is high exactly while at least one captured event is set.
- R12: Offsets 11 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on the next cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| line_in | input | 48 | Sensed level of each line |
| line_oe | output | 48 | Drive enable per line (1 drives high, 0 releases) |
| irq | output | 1 | Interrupt request, high while any event is captured |

## Verification
An event bit that is set wrongly or left set shows up at once on the interrupt output and in the offset 6 summary. A page register that is wrong shows up on the first access to offsets 8 to 10: the write lands in the wrong bank, or the read returns another bank. A lost clear or a lost re-arm is visible on the interrupt output in the cycle after the enable write. A fault in edge selection becomes visible three clock edges after the line changes, once the synchronizer and the previous-sample flop have been passed. The bench therefore samples events and the interrupt several cycles after each change of the lines. Reads are checked one cycle after the strobe.

// File: rtl/gpio48_pkg.sv
package gpio48_pkg;
   // page select codes written to the page register
   typedef enum logic [7:0] {
      PG_ENABLE   = 8'h80,
      PG_POLARITY = 8'h40,
      PG_EVENT    = 8'hC0
   } page_e;

   localparam int unsigned OFS_SUMMARY = 6;
   localparam int unsigned OFS_PAGE    = 7;
   localparam int unsigned OFS_BANK    = 8;
   localparam int unsigned ADDR_W      = 4;
   localparam int unsigned DATA_W      = 8;
endpackage

// File: rtl/gpio48_sync.sv
module gpio48_sync #(
   parameter int unsigned W      = 48,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio48_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio48_irq_port.sv
module gpio48_irq_port #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sync_in,
   input  logic         en_we,
   input  logic         pol_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en_q,
   output logic [W-1:0] pol_q,
   output logic [W-1:0] ev_q,
   output logic         pending
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise, fall, hit, en_next;

   assign rise    = sync_in & ~prev_q;
   assign fall    = ~sync_in & prev_q;
   assign hit     = (pol_q & rise) | (~pol_q & fall);
   assign en_next = en_we ? wdata : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         en_q   <= '0;
         pol_q  <= '0;
         ev_q   <= '0;
      end else begin
         prev_q <= sync_in;
         if (en_we)  en_q  <= wdata;
         if (pol_we) pol_q <= wdata;
         // capture with the current enable, drop anything whose enable goes low
         ev_q <= (ev_q | (hit & en_q)) & en_next;
      end
   end

   assign pending = |ev_q;
endmodule

// File: rtl/gpio48_edge_ctrl.sv
module gpio48_edge_ctrl
   import gpio48_pkg::*;
#(
   parameter int unsigned PORTS       = 6,
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned IRQ_PORTS   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [3:0]               bus_addr,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [7:0]               bus_wdata,
   output logic [7:0]               bus_rdata,
   input  logic [PORTS*PORT_W-1:0]  line_in,
   output logic [PORTS*PORT_W-1:0]  line_oe,
   output logic                     irq
);
   localparam int unsigned LINES     = PORTS * PORT_W;
   localparam int unsigned IRQ_LINES = IRQ_PORTS * PORT_W;

   if (PORT_W != DATA_W) begin : g_bad_width
      $error("gpio48_edge_ctrl: PORT_W must equal the bus data width");
   end
   if (PORTS > OFS_SUMMARY) begin : g_bad_ports
      $error("gpio48_edge_ctrl: too many ports for the offset map");
   end
   if (IRQ_PORTS == 0 || IRQ_PORTS > PORTS || IRQ_PORTS > DATA_W
       || OFS_BANK + IRQ_PORTS > (1 << ADDR_W)) begin : g_bad_irq
      $error("gpio48_edge_ctrl: IRQ_PORTS out of range");
   end

   logic [PORTS-1:0][PORT_W-1:0] latch_q;
   logic [LINES-1:0]             line_s;
   page_e                        page_q;
   logic [IRQ_LINES-1:0]         en_all, pol_all, ev_all;
   logic [IRQ_PORTS-1:0]         pend;
   logic [7:0]                   rd_mux;

   // output latches
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (bus_wr) begin
         for (int p = 0; p < PORTS; p++)
            if (bus_addr == ADDR_W'(p)) latch_q[p] <= bus_wdata;
      end
   end
   assign line_oe = latch_q;

   // page register; unknown codes leave the selection unchanged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= PG_EVENT;
      end else if (bus_wr && bus_addr == ADDR_W'(OFS_PAGE)) begin
         unique case (bus_wdata)
            PG_ENABLE:   page_q <= PG_ENABLE;
            PG_POLARITY: page_q <= PG_POLARITY;
            PG_EVENT:    page_q <= PG_EVENT;
            default:     page_q <= page_q;
         endcase
      end
   end

   gpio48_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (line_in),
      .q     (line_s)
   );

   for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq_port
      logic bank_hit;
      assign bank_hit = bus_wr && (bus_addr == ADDR_W'(OFS_BANK + p));

      gpio48_irq_port #(.W(PORT_W)) u_port (
         .clk     (clk),
         .rst_n   (rst_n),
         .sync_in (line_s[p*PORT_W +: PORT_W]),
         .en_we   (bank_hit && page_q == PG_ENABLE),
         .pol_we  (bank_hit && page_q == PG_POLARITY),
         .wdata   (bus_wdata),
         .en_q    (en_all[p*PORT_W +: PORT_W]),
         .pol_q   (pol_all[p*PORT_W +: PORT_W]),
         .ev_q    (ev_all[p*PORT_W +: PORT_W]),
         .pending (pend[p])
      );
   end

   // read selection
   always_comb begin
      rd_mux = '0;
      for (int p = 0; p < PORTS; p++)
         if (bus_addr == ADDR_W'(p)) rd_mux = line_s[p*PORT_W +: PORT_W];
      if (bus_addr == ADDR_W'(OFS_SUMMARY)) rd_mux = 8'(pend);
      if (bus_addr == ADDR_W'(OFS_PAGE))    rd_mux = page_q;
      for (int p = 0; p < IRQ_PORTS; p++) begin
         if (bus_addr == ADDR_W'(OFS_BANK + p)) begin
            unique case (page_q)
               PG_ENABLE:   rd_mux = en_all[p*PORT_W +: PORT_W];
               PG_POLARITY: rd_mux = pol_all[p*PORT_W +: PORT_W];
               default:     rd_mux = ev_all[p*PORT_W +: PORT_W];
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assign irq = |pend;
endmodule

// File: rtl/gpio48_chk.sv
module gpio48_chk #(
   parameter int unsigned PORTS     = 6,
   parameter int unsigned PORT_W    = 8,
   parameter int unsigned IRQ_PORTS = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [3:0]                    bus_addr,
   input logic                          bus_wr,
   input logic                          bus_rd,
   input logic [7:0]                    bus_wdata,
   input logic [7:0]                    bus_rdata,
   input logic [PORTS*PORT_W-1:0]       line_oe,
   input logic                          irq,
   input logic [7:0]                    page_q,
   input logic [IRQ_PORTS*PORT_W-1:0]   en_all,
   input logic [IRQ_PORTS*PORT_W-1:0]   pol_all,
   input logic [IRQ_PORTS*PORT_W-1:0]   ev_all
);
   // R2
   port0_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'd0) |=> (line_oe[PORT_W-1:0] == $past(bus_wdata)));

   // R7
   capture_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_all & ~$past(ev_all) & ~$past(en_all)) == '0));

   // R8
   event_page_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && page_q == 8'hC0 && bus_addr >= 4'd8)
      |=> ($stable(en_all) && $stable(pol_all)));

   // R9
   disable_clears_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'd8 && page_q == 8'h80)
      |=> ((ev_all[PORT_W-1:0] & ~$past(bus_wdata)) == '0));

   // R11
   irq_tracks_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq == (|ev_all)));

   // R12
   unused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr >= 4'd11) |=> (bus_rdata == 8'h00));
endmodule

bind gpio48_edge_ctrl gpio48_chk #(
   .PORTS(PORTS), .PORT_W(PORT_W), .IRQ_PORTS(IRQ_PORTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .line_oe   (line_oe),
   .irq       (irq),
   .page_q    (page_q),
   .en_all    (en_all),
   .pol_all   (pol_all),
   .ev_all    (ev_all)
);

// File: tb/tb_gpio48_edge_ctrl.sv
`timescale 1ns/1ps
module tb_gpio48_edge_ctrl;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [47:0] line_in = '0;
   logic [47:0] line_oe;
   logic        irq;

   int errors = 0, checks = 0;
   bit done = 0;

   // bench model
   logic [7:0]  m_latch [6];
   logic [23:0] m_en, m_pol, m_ev;
   logic [7:0]  m_page;
   logic [47:0] cur_in;

   gpio48_edge_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .line_in(line_in), .line_oe(line_oe), .irq(irq)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [3:0] a);
      logic [7:0] r = 8'h00;
      if (a < 6) r = cur_in[a*8 +: 8];
      else if (a == 6) r = {5'b0, |m_ev[23:16], |m_ev[15:8], |m_ev[7:0]};
      else if (a == 7) r = m_page;
      else if (a <= 10) begin
         case (m_page)
            8'h80:   r = m_en[(a-8)*8 +: 8];
            8'h40:   r = m_pol[(a-8)*8 +: 8];
            default: r = m_ev[(a-8)*8 +: 8];
         endcase
      end
      return r;
   endfunction

   function automatic string req_of(input logic [3:0] a);
      if (a < 6) return "R3";
      if (a == 6) return "R10";
      if (a == 7) return "R4";
      if (a <= 10) return (m_page == 8'hC0) ? "R8" : ((m_page == 8'h80) ? "R5" : "R6");
      return "R12";
   endfunction

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk);
      bus_wr = 0;
      if (a < 6) m_latch[a] = d;
      else if (a == 7) begin
         if (d == 8'h80 || d == 8'h40 || d == 8'hC0) m_page = d;
      end else if (a >= 8 && a <= 10) begin
         if (m_page == 8'h80) begin
            m_en[(a-8)*8 +: 8] = d;
            m_ev[(a-8)*8 +: 8] &= d;
         end else if (m_page == 8'h40) m_pol[(a-8)*8 +: 8] = d;
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1;
      @(negedge clk);
      bus_rd = 0;
      v = bus_rdata;
   endtask

   task automatic rd_check(input logic [3:0] a, input string req);
      logic [7:0] v;
      rd(a, v);
      check(req, v, exp_read(a));
   endtask

   task automatic drive(input logic [47:0] nv);
      logic [23:0] hit;
      hit = (m_pol & ~cur_in[23:0] & nv[23:0]) | (~m_pol & cur_in[23:0] & ~nv[23:0]);
      m_ev |= hit & m_en;
      cur_in = nv;
      @(negedge clk);
      line_in = nv;
      repeat (5) @(negedge clk);
   endtask

   task automatic check_pins(input string req);
      logic [47:0] eo;
      for (int p = 0; p < 6; p++) eo[p*8 +: 8] = m_latch[p];
      check(req, line_oe, eo);
      check("R11", irq, |m_ev);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd20240611));
      for (int p = 0; p < 6; p++) m_latch[p] = 8'h00;
      m_en = '0; m_pol = '0; m_ev = '0; m_page = 8'hC0; cur_in = '0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1", line_oe, 48'h0);
      check("R1", irq, 1'b0);
      rd_check(4'd7, "R1");
      for (int a = 8; a <= 10; a++) rd_check(4'(a), "R1");
      rd_check(4'd6, "R1");

      // R2 latches drive pins
      wr(4'd3, 8'hA5);
      wr(4'd0, 8'h3C);
      check_pins("R2");

      // R3 input sampling
      drive(48'h5A00_0000_0000);
      rd_check(4'd5, "R3");
      rd_check(4'd4, "R3");

      // R4 page codes; bad code ignored
      wr(4'd7, 8'h12);
      rd_check(4'd7, "R4");
      wr(4'd7, 8'h80);
      rd_check(4'd7, "R4");

      // R5 enable page
      wr(4'd8, 8'h08);
      wr(4'd9, 8'h01);
      rd_check(4'd8, "R5");
      rd_check(4'd9, "R5");

      // R6 polarity: port1 rising, port0 falling
      wr(4'd7, 8'h40);
      wr(4'd9, 8'hFF);
      rd_check(4'd9, "R6");
      drive(cur_in | 48'h0000_0000_0108);   // line 8 rises, line 3 rises (falling selected)
      wr(4'd7, 8'hC0);
      rd_check(4'd9, "R6");
      rd_check(4'd8, "R6");
      drive(cur_in & ~48'h0000_0000_0008);  // line 3 falls
      rd_check(4'd8, "R6");
      check_pins("R11");

      // R7 edges on pure I/O ports and disabled lines are not captured
      drive(cur_in ^ 48'hFFFF_FF00_F0F0);
      rd_check(4'd6, "R7");
      rd_check(4'd10, "R7");

      // R8 writes in event page ignored
      wr(4'd9, 8'h00);
      rd_check(4'd9, "R8");
      wr(4'd7, 8'h80);
      rd_check(4'd8, "R8");

      // R9 clear then re-arm
      wr(4'd8, 8'h00);
      wr(4'd9, 8'h00);
      check_pins("R9");
      wr(4'd8, 8'h08);
      wr(4'd9, 8'h01);
      wr(4'd7, 8'hC0);
      rd_check(4'd6, "R9");
      drive(cur_in & ~48'h0000_0000_0100);  // line 8 falls, not selected
      drive(cur_in | 48'h0000_0000_0108);   // line 8 rises again
      rd_check(4'd9, "R9");

      // R10 summary
      rd_check(4'd6, "R10");

      // R12 unused offsets
      for (int a = 11; a <= 15; a++) rd_check(4'(a), "R12");

      // constrained random phase
      for (int i = 0; i < 400; i++) begin
         int op;
         logic [3:0] a;
         logic [7:0] d;
         op = $urandom_range(0, 9);
         a  = 4'($urandom_range(0, 15));
         d  = 8'($urandom);
         if (op < 4) begin
            if (a == 7 && $urandom_range(0, 1) == 1) begin
               case ($urandom_range(0, 2))
                  0: d = 8'h80;
                  1: d = 8'h40;
                  default: d = 8'hC0;
               endcase
            end
            wr(a, d);
            check_pins(a < 6 ? "R2" : (a >= 8 && a <= 10 ? "R9" : "R4"));
         end else if (op < 6) begin
            drive({16'($urandom), $urandom});
            check_pins("R7");
         end else begin
            rd_check(a, req_of(a));
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule